// File: doc/BRIEF.md
# ALU with Condition-Flag Register

This block is a 32-bit arithmetic and logic unit. It has its own file of four data registers and a status word that holds four condition flags: Zero, Negative, Carry and oVerflow.

Each cycle it takes three inputs:

- an operation code;
- a 4-bit register field, where bits 1:0 name the destination register and bits 3:2 name a source register;
- a select bit that picks either that source register or a 32-bit immediate as the source operand.

The operations are add, subtract, compare, OR, XOR and bit-test. Add, subtract, OR and XOR write their result back to the destination register. Compare and bit-test only set the flags. The register write and the flag update land together on the rising clock edge that ends the cycle.

Each operation sets the flags by its own rule. The arithmetic operations produce a real carry or borrow and a signed overflow. The logical operations force Carry and oVerflow to zero. Status-word bits above the four flags are never touched by an operation. A synchronous, active-high reset clears every register and the whole status word.

Top module: `aluf_top`

## Requirements
- R1: While `rst` is high at a clock edge, all four registers and every bit of `psw_o` become zero.
- R2: Opcode 1 (add) writes dest + source (mod 2^32) to the destination register. It sets C (psw_o bit 2) exactly when the true sum exceeds 2^32 − 1.
- R3: Add sets V (psw_o bit 3) when the two operands share bit 31 and the sum's bit 31 differs from that shared sign.
- R4: Opcode 2 (subtract) writes dest − source to the destination. C is set when source > dest as unsigned values. V is set when the operand sign bits differ and the result's bit 31 differs from dest's bit 31.
- R5: Opcode 3 (compare) computes register − source, writes no register, and sets C when source > register as unsigned values. V follows the R4 rule with the register in the role of dest.
- R6: Opcodes 4 (OR) and 5 (XOR) write the bitwise result to the destination and clear both C and V.
- R7: Opcode 6 (bit-test) forms register AND source, writes no register, sets Z and N from that value, and clears C and V.
- R8: For every opcode from 1 to 6, Z (psw_o bit 0) is 1 exactly when the 32-bit result is zero, and N (psw_o bit 1) equals bit 31 of the result.
- R9: The destination index is `instr_i[1:0]`. When `src_reg_i` is 1 the source operand is the register named by `instr_i[3:2]`; otherwise it is `imm_i`.
- R10: Opcodes 0 and 7 change no register and no `psw_o` bit. Bits of `psw_o` above bit 3 are never changed by any operation.
- R11: The register write-back and the flag update of an operation both appear on the outputs right after the first rising edge at which that operation is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 3 | Operation code (0 none, 1 add, 2 sub, 3 cmp, 4 or, 5 xor, 6 bit-test, 7 none) |
| instr_i | input | 4 | Register field: [1:0] destination, [3:2] source register |
| src_reg_i | input | 1 | 1 selects the source register, 0 selects the immediate |
| imm_i | input | 32 | Immediate source operand |
| regs_o | output | 128 | All four registers, register k in bits 32k+31:32k |
| psw_o | output | 8 | Status word: bit 0 Z, bit 1 N, bit 2 C, bit 3 V, bits 7:4 held |

## Verification
Operand pairs taken from the corner set 0, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF go through add, subtract, compare and bit-test. These pairs separate carry from signed overflow, show the borrow when the source is larger, and show the zero and sign results at the wrap points. Random operations with mixed register and immediate sources check that the right register is read and written. Because some of them write a register onto itself, a missing or misrouted write-back shows up on a later operation. The two no-op codes and the compare and bit-test operations are checked for leaving the register file unchanged.

// File: rtl/aluf_pkg.sv
package aluf_pkg;
  localparam int unsigned FLAG_Z = 0;
  localparam int unsigned FLAG_N = 1;
  localparam int unsigned FLAG_C = 2;
  localparam int unsigned FLAG_V = 3;
  localparam int unsigned NUM_FLAGS = 4;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_ADD  = 3'd1,
    OP_SUB  = 3'd2,
    OP_CMP  = 3'd3,
    OP_OR   = 3'd4,
    OP_XOR  = 3'd5,
    OP_BTST = 3'd6,
    OP_RSV  = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic v;
    logic c;
    logic n;
    logic z;
  } flags_t;
endpackage

// File: rtl/aluf_core.sv
module aluf_core
  import aluf_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   dst_val,
  input  logic [W-1:0]   src_val,
  output logic [W-1:0]   res,
  output flags_t         flg,
  output logic           wr_en,
  output logic           flg_upd
);
  localparam int unsigned SB = W - 1;

  // Returns {carry, overflow, sum}
  function automatic logic [W+1:0] add_cv(input logic [W-1:0] d, input logic [W-1:0] s);
    logic [W-1:0] r;
    r = d + s;
    return {(r < s) || (r < d), (d[SB] == s[SB]) && (r[SB] != d[SB]), r};
  endfunction

  // Returns {borrow, overflow, difference} for d - s
  function automatic logic [W+1:0] sub_cv(input logic [W-1:0] d, input logic [W-1:0] s);
    logic [W-1:0] r;
    r = d - s;
    return {s > d, (d[SB] != s[SB]) && (r[SB] != d[SB]), r};
  endfunction

  logic [W+1:0] arith;

  always_comb begin
    arith   = '0;
    res     = '0;
    wr_en   = 1'b0;
    flg_upd = 1'b1;
    case (op)
      OP_ADD:  begin arith = add_cv(dst_val, src_val); res = arith[W-1:0]; wr_en = 1'b1; end
      OP_SUB:  begin arith = sub_cv(dst_val, src_val); res = arith[W-1:0]; wr_en = 1'b1; end
      OP_CMP:  begin arith = sub_cv(dst_val, src_val); res = arith[W-1:0]; end
      OP_OR:   begin res = dst_val | src_val; wr_en = 1'b1; end
      OP_XOR:  begin res = dst_val ^ src_val; wr_en = 1'b1; end
      OP_BTST: begin res = dst_val & src_val; end
      default: flg_upd = 1'b0;
    endcase
    flg.z = (res == '0);
    flg.n = res[SB];
    flg.c = arith[W+1];
    flg.v = arith[W];
  end
endmodule

// File: rtl/aluf_regfile.sv
module aluf_regfile #(
  parameter int unsigned W  = 32,
  parameter int unsigned N  = 4,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [IW-1:0]   widx,
  input  logic [W-1:0]    wdata,
  input  logic [IW-1:0]   ra,
  input  logic [IW-1:0]   rb,
  output logic [W-1:0]    rdata_a,
  output logic [W-1:0]    rdata_b,
  output logic [N*W-1:0]  flat
);
  for (genvar g = 0; g < N; g++) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else if (we && (widx == IW'(g))) q <= wdata;
    end
    assign flat[g*W +: W] = q;
  end

  assign rdata_a = flat[ra*W +: W];
  assign rdata_b = flat[rb*W +: W];

  // R10: without a write strobe no register moves
  p_hold_no_write_r10: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(flat));
  // R1: reset empties the file
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (flat == '0));
endmodule

// File: rtl/aluf_psw.sv
module aluf_psw
  import aluf_pkg::*;
#(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd,
  input  flags_t        nflags,
  output logic [PW-1:0] psw
);
  localparam int unsigned FW = NUM_FLAGS;

  always_ff @(posedge clk) begin
    if (rst) psw <= '0;
    else if (upd) psw[FW-1:0] <= nflags;
  end

  // R10: upper status bits never move after reset
  p_upper_hold_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(psw[PW-1:FW]));
  // R1: reset clears the whole word
  p_psw_reset_r1: assert property (@(posedge clk)
    rst |=> (psw == '0));
endmodule

// File: rtl/aluf_top.sv
module aluf_top
  import aluf_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned N  = 4,
  parameter int unsigned PW = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op_i,
  input  logic [2*IW-1:0]   instr_i,
  input  logic              src_reg_i,
  input  logic [W-1:0]      imm_i,
  output logic [N*W-1:0]    regs_o,
  output logic [PW-1:0]     psw_o
);
  alu_op_e      op;
  logic [IW-1:0] dst_idx, src_idx;
  logic [W-1:0] dst_val, src_reg_val, src_val, alu_res;
  flags_t       alu_flg;
  logic         wr_en, flg_upd;

  assign op      = alu_op_e'(op_i);
  assign dst_idx = instr_i[IW-1:0];
  assign src_idx = instr_i[2*IW-1:IW];
  assign src_val = src_reg_i ? src_reg_val : imm_i;

  aluf_regfile #(.W(W), .N(N)) u_rf (
    .clk(clk), .rst(rst), .we(wr_en), .widx(dst_idx), .wdata(alu_res),
    .ra(dst_idx), .rb(src_idx), .rdata_a(dst_val), .rdata_b(src_reg_val),
    .flat(regs_o)
  );

  aluf_core #(.W(W)) u_core (
    .op(op), .dst_val(dst_val), .src_val(src_val), .res(alu_res),
    .flg(alu_flg), .wr_en(wr_en), .flg_upd(flg_upd)
  );

  aluf_psw #(.PW(PW)) u_psw (
    .clk(clk), .rst(rst), .upd(flg_upd), .nflags(alu_flg), .psw(psw_o)
  );

  // R5: compare leaves the register file alone
  p_cmp_nowrite_r5: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CMP) |=> $stable(regs_o));
  // R7: bit-test leaves the register file alone
  p_btst_nowrite_r7: assert property (@(posedge clk) disable iff (rst)
    (op == OP_BTST) |=> $stable(regs_o));
  // R6: logical results carry no C or V
  p_logic_cv_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (op == OP_OR || op == OP_XOR || op == OP_BTST) |=> (psw_o[FLAG_C] == 1'b0 && psw_o[FLAG_V] == 1'b0));
  // R8: Z and N follow the result of the operation one edge earlier
  p_zn_follow_r8: assert property (@(posedge clk) disable iff (rst)
    flg_upd |=> (psw_o[FLAG_Z] == ($past(alu_res) == '0)) && (psw_o[FLAG_N] == $past(alu_res[W-1])));
  // R2: add carry equals an unsigned wrap of the sum
  p_add_carry_r2: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ADD) |=> (psw_o[FLAG_C] == ($past(alu_res) < $past(src_val))));
  // R10: the idle codes change nothing
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (op == OP_NOP || op == OP_RSV) |=> ($stable(psw_o) && $stable(regs_o)));
endmodule

// File: tb/aluf_top_tb_top.sv
module aluf_top_tb_top;
  logic         clk = 1'b0;
  logic         rst;
  logic [2:0]   op_i;
  logic [3:0]   instr_i;
  logic         src_reg_i;
  logic [31:0]  imm_i;
  logic [127:0] regs_o;
  logic [7:0]   psw_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_reg [4];
  logic [7:0]  m_psw;

  always #2 clk = ~clk;

  aluf_top dut_i (
    .clk(clk), .rst(rst), .op_i(op_i), .instr_i(instr_i),
    .src_reg_i(src_reg_i), .imm_i(imm_i), .regs_o(regs_o), .psw_o(psw_o)
  );

  function automatic logic [127:0] m_flat();
    return {m_reg[3], m_reg[2], m_reg[1], m_reg[0]};
  endfunction

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd1: return "R2 R3 R8";
      3'd2: return "R4 R8";
      3'd3: return "R5 R8";
      3'd4, 3'd5: return "R6 R8";
      3'd6: return "R7 R8";
      default: return "R10";
    endcase
  endfunction

  // reference: result, write flag, flags {v,c,n,z}
  task automatic model(input logic [2:0] op, input logic [3:0] ins, input logic sr, input logic [31:0] imm);
    logic [31:0] d, s, r;
    logic [32:0] wide;
    logic c, v, wr, upd;
    d = m_reg[ins[1:0]];
    s = sr ? m_reg[ins[3:2]] : imm;
    c = 0; v = 0; wr = 0; upd = 1; r = 0;
    case (op)
      3'd1: begin wide = {1'b0, d} + {1'b0, s}; r = wide[31:0]; c = wide[32];
              v = (d[31] & s[31] & ~r[31]) | (~d[31] & ~s[31] & r[31]); wr = 1; end
      3'd2, 3'd3: begin wide = {1'b0, d} - {1'b0, s}; r = wide[31:0]; c = wide[32];
              v = (d[31] & ~s[31] & ~r[31]) | (~d[31] & s[31] & r[31]); wr = (op == 3'd2); end
      3'd4: begin r = d | s; wr = 1; end
      3'd5: begin r = d ^ s; wr = 1; end
      3'd6: begin r = d & s; end
      default: upd = 0;
    endcase
    if (wr) m_reg[ins[1:0]] = r;
    if (upd) m_psw[3:0] = {v, c, r[31], (r == 32'd0)};
  endtask

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive on falling edge, sample just after the next rising edge (R11)
  task automatic run_op(input logic [2:0] op, input logic [3:0] ins, input logic sr, input logic [31:0] imm);
    @(negedge clk);
    op_i = op; instr_i = ins; src_reg_i = sr; imm_i = imm;
    model(op, ins, sr, imm);
    @(posedge clk); #1;
    chk({req_of(op), " R9 R11 regs"}, regs_o, m_flat());
    chk({req_of(op), " R11 psw"}, {120'd0, psw_o}, {120'd0, m_psw});
  endtask

  task automatic load_reg(input logic [1:0] idx, input logic [31:0] val);
    run_op(3'd5, {idx, idx}, 1'b1, 32'd0);   // self XOR -> 0
    run_op(3'd4, {2'd0, idx}, 1'b0, val);    // OR immediate
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] corner [4];
    process::self().srandom(32'd1234);
    corner[0] = 32'h0; corner[1] = 32'h7FFF_FFFF; corner[2] = 32'h8000_0000; corner[3] = 32'hFFFF_FFFF;
    rst = 1; op_i = 0; instr_i = 0; src_reg_i = 0; imm_i = 0;
    foreach (m_reg[k]) m_reg[k] = 0;
    m_psw = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 regs", regs_o, 128'd0);
    chk("R1 psw", {120'd0, psw_o}, 128'd0);
    @(negedge clk); rst = 0;

    // directed corners through the arithmetic and bit-test ops
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int o = 1; o <= 6; o++) begin
          if (o == 4 || o == 5) continue;
          load_reg(2'd1, corner[a]);
          run_op(3'(o), 4'b0001, 1'b0, corner[b]);
        end

    // same-register source (R9)
    load_reg(2'd2, 32'h8000_0000);
    run_op(3'd1, 4'b1010, 1'b1, 32'h0);   // 0x80000000+itself -> 0, C=1, V=1
    chk("R2 R3 R8 self add flags", {120'd0, psw_o}, {120'd0, 8'b0000_1101});

    // idle codes (R10)
    load_reg(2'd3, 32'h1234_5678);
    run_op(3'd1, 4'b0011, 1'b0, 32'hFFFF_FFFF);
    run_op(3'd0, 4'b0011, 1'b0, 32'h1);
    run_op(3'd7, 4'b1111, 1'b1, 32'h5);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] im;
      int sel;
      sel = $urandom_range(0, 3);
      im = (sel == 0) ? corner[$urandom_range(0, 3)] : $urandom;
      run_op(3'($urandom_range(0, 7)), 4'($urandom), 1'($urandom), im);
    end

    // reset again mid-run (R1)
    @(negedge clk); rst = 1;
    foreach (m_reg[k]) m_reg[k] = 0;
    m_psw = 0;
    @(posedge clk); #1;
    chk("R1 rerst regs", regs_o, 128'd0);
    chk("R1 rerst psw", {120'd0, psw_o}, 128'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule